// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Engine

This block is the slave side of a serial-flash-style byte store: an on-chip array of 512 bytes that is reached only through a four-wire serial link. A host lowers chip select and shifts in a command byte, an address byte and, for stores, data bytes. For a fetch, the block streams bytes back on the serial output for as long as the host keeps clocking, stepping the address by one after each byte.

A store collects between one and eight bytes into an eight-byte page buffer. After chip select rises on a byte boundary, the page is committed through an internally timed write cycle. Busy stays high for that cycle, and no new command is accepted until it ends. A separate protection unit decides through the write-allowed input whether a commit may happen at all. A hold input lets the host pause a transfer in the middle of a byte and resume it later.

The serial pins are sampled by a fast system clock. Edges of the serial clock are detected after a synchronizer, so every serial clock phase must last several system clocks.

Top module: `eeprom_spi_slave`

## Requirements
- R1: Serial input is captured on rising serial-clock edges and the serial output changes only on falling edges, so both clock-idle-low (mode 0) and clock-idle-high (mode 3) hosts are served.
- R2: Command, address and data bytes travel most significant bit first.
- R3: A command byte of the form 0000_A011 (A = address bit 8), followed by one byte holding address bits 7:0, starts a fetch. Bytes are then returned back to back, starting at that address, and the address advances by one after each byte.
- R4: During a fetch the address steps from 511 to 0 and streaming continues.
- R5: A command byte of the form 0000_A010 followed by an address byte starts a store. One to eight data bytes that follow are placed at successive addresses inside the eight-byte page holding the start address.
- R6: When more than eight data bytes are sent, the low three address bits wrap inside the same page, and later bytes overwrite earlier ones.
- R7: A store ended by chip select rising on a byte boundary commits the page. Busy is then high for exactly WR_CYCLES system clocks, and the new bytes are readable once busy has fallen.
- R8: A store ended by chip select rising part-way through a byte commits nothing and does not raise busy.
- R9: A store whose write-allowed input is low when chip select rises commits nothing and does not raise busy.
- R10: While busy is high, any new command is ignored: a fetch drives nothing and a store commits nothing.
- R11: While hold is low, serial-clock edges are ignored and the bit position, address and command progress are kept; the transfer continues unchanged once hold returns high.
- R12: The output enable is low whenever chip select is high or hold is low, and after reset.
- R13: A command byte that matches neither the fetch nor the store pattern is ignored for the rest of the selection, and the output is never enabled.
- R14: After reset, busy is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Active-low transfer pause |
| wr_allow | input | 1 | High when the protection unit permits a commit |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Drive enable for the serial output pad |
| busy | output | 1 | High for the duration of an internal write cycle |

## Verification
Fetches are issued in both clock polarities. Byte patterns with distinct high and low nibbles show whether the bit order or an address offset is wrong. Single-byte, full-page and over-length stores separate correct lane placement from mis-wrapped page offsets. A fetch that starts just below the top of the array shows whether the address counter wraps to zero or overflows into the wrong location. Stores that end mid-byte, that lack write permission or that are sent while busy are followed by fetches of the targeted bytes, which must still hold their old values. A mid-byte hold with extra clock pulses shows whether those pulses were ignored.

// File: rtl/eeprom_spi_pkg.sv
package eeprom_spi_pkg;
  localparam int ADDR_W = 9;
  localparam int BYTE_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [2:0] {
    PH_OPCODE,
    PH_ADDR,
    PH_RDATA,
    PH_WDATA,
    PH_SKIP
  } phase_t;

  localparam logic [2:0] OPC_READ_LO  = 3'b011;
  localparam logic [2:0] OPC_WRITE_LO = 3'b010;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_hi,
  output logic cs_rise,
  output logic si_s,
  output logic hold_ok
);
  logic [STAGES-1:0] sck_c, cs_c, si_c, hold_c;
  logic sck_prev, cs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_c    <= '0;
      cs_c     <= '1;
      si_c     <= '0;
      hold_c   <= '1;
      sck_prev <= 1'b0;
      cs_prev  <= 1'b1;
    end else begin
      sck_c    <= {sck_c[STAGES-2:0], sck};
      cs_c     <= {cs_c[STAGES-2:0], cs_n};
      si_c     <= {si_c[STAGES-2:0], si};
      hold_c   <= {hold_c[STAGES-2:0], hold_n};
      sck_prev <= sck_c[STAGES-1];
      cs_prev  <= cs_c[STAGES-1];
    end
  end

  assign sck_rise = sck_c[STAGES-1] & ~sck_prev;
  assign sck_fall = ~sck_c[STAGES-1] & sck_prev;
  assign cs_hi    = cs_c[STAGES-1];
  assign cs_rise  = cs_c[STAGES-1] & ~cs_prev;
  assign si_s     = si_c[STAGES-1];
  assign hold_ok  = hold_c[STAGES-1];
endmodule

// File: rtl/eeprom_wr_timer.sv
module eeprom_wr_timer #(
  parameter int WR_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic commit_now
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d     = busy_q;
    cnt_d      = cnt_q;
    commit_now = 1'b0;
    if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d     = 1'b0;
        commit_now = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(WR_CYCLES - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store
  import eeprom_spi_pkg::*;
#(
  parameter int PAGE_BYTES = 8
) (
  input  logic                                   clk,
  input  logic [ADDR_W-1:0]                      rd_addr,
  output logic [BYTE_W-1:0]                      rd_data,
  input  logic                                   we,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]   page_idx,
  input  logic [PAGE_BYTES-1:0][BYTE_W-1:0]      page_data,
  input  logic [PAGE_BYTES-1:0]                  page_mask
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (page_mask[i]) mem[{page_idx, PAGE_W'(i)}] <= page_data[i];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eeprom_cmd_fsm.sv
module eeprom_cmd_fsm
  import eeprom_spi_pkg::*;
#(
  parameter int PAGE_BYTES = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 sck_rise,
  input  logic                                 sck_fall,
  input  logic                                 cs_hi,
  input  logic                                 cs_rise,
  input  logic                                 si_s,
  input  logic                                 hold_ok,
  input  logic                                 busy,
  input  logic                                 wr_allow,
  input  logic [BYTE_W-1:0]                    rd_data,
  output logic [ADDR_W-1:0]                    rd_addr,
  output logic                                 commit_req,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_idx,
  output logic [PAGE_BYTES-1:0][BYTE_W-1:0]    page_data,
  output logic [PAGE_BYTES-1:0]                page_mask,
  output logic                                 so,
  output logic                                 so_oe,
  output phase_t                               state,
  output logic [2:0]                           bitcnt,
  output logic [ADDR_W-1:0]                    addr
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  phase_t                  state_q, state_d;
  logic [2:0]              bit_q, bit_d;
  logic [BYTE_W-1:0]       sh_q, sh_d;
  logic [BYTE_W-1:0]       tx_q, tx_d;
  logic [ADDR_W-1:0]       addr_q, addr_d;
  logic                    hi_q, hi_d;
  logic                    wr_q, wr_d;
  logic                    so_q, so_d;
  logic [PAGE_BYTES-1:0]   mask_q, mask_d;
  logic [PAGE_BYTES-1:0][BYTE_W-1:0] pbuf_q;
  logic                    buf_we;
  logic                    active;
  logic [BYTE_W-1:0]       byte_in;

  assign active  = ~cs_hi & hold_ok;
  assign byte_in = {sh_q[BYTE_W-2:0], si_s};

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    addr_d  = addr_q;
    hi_d    = hi_q;
    wr_d    = wr_q;
    so_d    = so_q;
    mask_d  = mask_q;
    buf_we  = 1'b0;
    if (cs_hi) begin
      state_d = PH_OPCODE;
      bit_d   = '0;
    end else if (active) begin
      if (sck_rise) begin
        bit_d = bit_q + 3'd1;
        sh_d  = byte_in;
        if (bit_q == 3'd7) begin
          unique case (state_q)
            PH_OPCODE: begin
              hi_d = byte_in[3];
              if (busy || byte_in[7:4] != 4'd0) begin
                state_d = PH_SKIP;
              end else if (byte_in[2:0] == OPC_READ_LO) begin
                state_d = PH_ADDR;
                wr_d    = 1'b0;
              end else if (byte_in[2:0] == OPC_WRITE_LO) begin
                state_d = PH_ADDR;
                wr_d    = 1'b1;
              end else begin
                state_d = PH_SKIP;
              end
            end
            PH_ADDR: begin
              addr_d = {hi_q, byte_in};
              if (wr_q) begin
                state_d = PH_WDATA;
                mask_d  = '0;
              end else begin
                state_d = PH_RDATA;
                tx_d    = rd_data;
              end
            end
            PH_RDATA: begin
              addr_d = addr_q + 9'd1;
              tx_d   = rd_data;
            end
            PH_WDATA: begin
              buf_we                     = 1'b1;
              mask_d[addr_q[PAGE_W-1:0]] = 1'b1;
              addr_d[PAGE_W-1:0]         = addr_q[PAGE_W-1:0] + 1'b1;
            end
            default: ;
          endcase
        end
      end else if (sck_fall && state_q == PH_RDATA) begin
        so_d = tx_q[BYTE_W-1];
        tx_d = {tx_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_OPCODE;
      bit_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      hi_q    <= 1'b0;
      wr_q    <= 1'b0;
      so_q    <= 1'b0;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      addr_q  <= addr_d;
      hi_q    <= hi_d;
      wr_q    <= wr_d;
      so_q    <= so_d;
      mask_q  <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf_q[addr_q[PAGE_W-1:0]] <= byte_in;
  end

  assign rd_addr    = (state_q == PH_ADDR) ? {hi_q, byte_in} : addr_q + 9'd1;
  assign commit_req = cs_rise & (state_q == PH_WDATA) & (bit_q == 3'd0)
                      & (|mask_q) & wr_allow;
  assign page_idx   = addr_q[ADDR_W-1:PAGE_W];
  assign page_data  = pbuf_q;
  assign page_mask  = mask_q;
  assign so         = so_q;
  assign so_oe      = active & (state_q == PH_RDATA);
  assign state      = state_q;
  assign bitcnt     = bit_q;
  assign addr       = addr_q;
endmodule

// File: rtl/eeprom_spi_slave.sv
module eeprom_spi_slave
  import eeprom_spi_pkg::*;
#(
  parameter int PAGE_BYTES  = 8,
  parameter int WR_CYCLES   = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  input  logic wr_allow,
  output logic so,
  output logic so_oe,
  output logic busy
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic sck_rise, sck_fall, cs_hi, cs_rise, si_s, hold_ok;
  logic commit_req, commit_now;
  logic [ADDR_W-1:0] rd_addr, addr;
  logic [BYTE_W-1:0] rd_data;
  logic [ADDR_W-PAGE_W-1:0] page_idx;
  logic [PAGE_BYTES-1:0][BYTE_W-1:0] page_data;
  logic [PAGE_BYTES-1:0] page_mask;
  phase_t state;
  logic [2:0] bitcnt;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_hi(cs_hi), .cs_rise(cs_rise),
    .si_s(si_s), .hold_ok(hold_ok)
  );

  eeprom_cmd_fsm #(.PAGE_BYTES(PAGE_BYTES)) fsm_i (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_hi(cs_hi), .cs_rise(cs_rise), .si_s(si_s), .hold_ok(hold_ok),
    .busy(busy), .wr_allow(wr_allow), .rd_data(rd_data), .rd_addr(rd_addr),
    .commit_req(commit_req), .page_idx(page_idx), .page_data(page_data),
    .page_mask(page_mask), .so(so), .so_oe(so_oe), .state(state),
    .bitcnt(bitcnt), .addr(addr)
  );

  eeprom_wr_timer #(.WR_CYCLES(WR_CYCLES)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(commit_req), .busy(busy),
    .commit_now(commit_now)
  );

  eeprom_store #(.PAGE_BYTES(PAGE_BYTES)) store_i (
    .clk(clk), .rd_addr(rd_addr), .rd_data(rd_data), .we(commit_now),
    .page_idx(page_idx), .page_data(page_data), .page_mask(page_mask)
  );
endmodule

// File: rtl/eeprom_spi_chk.sv
module eeprom_spi_chk
  import eeprom_spi_pkg::*;
#(
  parameter int WR_CYCLES = 5000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              cs_hi,
  input logic              cs_rise,
  input logic              hold_ok,
  input logic              wr_allow,
  input logic              so_oe,
  input phase_t            state,
  input logic [2:0]        bitcnt,
  input logic [ADDR_W-1:0] addr
);
  localparam int RUN_W = $clog2(WR_CYCLES + 2);
  logic [RUN_W-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else busy_run <= '0;
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_run < RUN_W'(WR_CYCLES)); // R7
  AST_BUSY_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (state == PH_OPCODE || state == PH_SKIP)); // R10
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_hi) |=> (!so_oe && state == PH_OPCODE)); // R12
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_ok && !cs_hi) |=> ($stable(bitcnt) && $stable(state) && $stable(addr))); // R11
  AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_RDATA && !cs_hi) |=> (addr == $past(addr) || addr == 9'($past(addr) + 9'd1))); // R4
  AST_PARTIAL_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && bitcnt != 3'd0 && !busy) |=> !busy); // R8
  AST_PROTECT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !wr_allow && !busy) |=> !busy); // R9
endmodule

bind eeprom_spi_slave eeprom_spi_chk #(.WR_CYCLES(WR_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cs_hi(cs_hi), .cs_rise(cs_rise),
  .hold_ok(hold_ok), .wr_allow(wr_allow), .so_oe(so_oe), .state(state),
  .bitcnt(bitcnt), .addr(addr)
);

// File: tb/eeprom_spi_slave_tb_top.sv
module eeprom_spi_slave_tb_top;
  localparam int WR   = 1500;
  localparam int HALF = 6;

  logic clk, rst_n, sck, cs_n, si, hold_n, wr_allow;
  logic so, so_oe, busy;

  int checks, fails;
  bit done;
  bit oe_seen;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  eeprom_spi_slave #(.PAGE_BYTES(8), .WR_CYCLES(WR), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .hold_n(hold_n), .wr_allow(wr_allow), .so(so), .so_oe(so_oe), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, output logic r);
    sck = 1'b0;
    si  = b;
    wait_clk(HALF);
    r = so;
    if (so_oe) oe_seen = 1'b1;
    sck = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      spi_bit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic spi_begin(input bit mode3);
    sck = mode3;
    wait_clk(HALF);
    cs_n = 1'b0;
    oe_seen = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic spi_end(input bit mode3);
    if (!mode3) begin
      sck = 1'b0;
      wait_clk(HALF);
    end
    cs_n = 1'b1;
    wait_clk(1);
  endtask

  // counts busy-high cycles after a deselect
  task automatic wait_busy(output int n);
    bit seen;
    n = 0;
    seen = 0;
    for (int k = 0; k < WR + 50; k++) begin
      @(negedge clk);
      if (busy) begin
        n++;
        seen = 1;
      end else if (seen) begin
        break;
      end
    end
    wait_clk(HALF);
  endtask

  task automatic eeprom_write(input logic [8:0] a, input int n, input bit allow,
                              input int extra_bits);
    logic [7:0] rx;
    logic r;
    wr_allow = allow;
    spi_begin(1'b0);
    spi_byte({4'b0000, a[8], 3'b010}, rx);
    spi_byte(a[7:0], rx);
    for (int i = 0; i < n; i++) spi_byte(wbuf[i], rx);
    for (int i = 0; i < extra_bits; i++) spi_bit(1'b1, r);
    spi_end(1'b0);
  endtask

  task automatic eeprom_read(input logic [8:0] a, input int n, input bit mode3);
    logic [7:0] rx;
    spi_begin(mode3);
    spi_byte({4'b0000, a[8], 3'b011}, rx);
    spi_byte(a[7:0], rx);
    for (int i = 0; i < n; i++) spi_byte(8'h00, rbuf[i]);
    spi_end(mode3);
    wait_clk(HALF);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0; hold_n = 1'b1; wr_allow = 1'b1;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    check("R14 busy after reset", int'(busy), 0);
    check("R12 so_oe after reset", int'(so_oe), 0);
  endtask

  task automatic t_single_write;
    int n;
    wbuf[0] = 8'h5A;
    eeprom_write(9'h123, 1, 1'b1, 0);
    wait_busy(n);
    check("R7 busy length", n, WR);
    eeprom_read(9'h123, 1, 1'b0);
    check("R3 R5 single byte readback", int'(rbuf[0]), 'h5A);
  endtask

  task automatic t_page_mode3;
    int n;
    for (int i = 0; i < 8; i++) wbuf[i] = 8'hA0 + 8'(i);
    eeprom_write(9'h040, 8, 1'b1, 0);
    wait_busy(n);
    check("R7 page commit busy", n, WR);
    eeprom_read(9'h040, 8, 1'b1);
    for (int i = 0; i < 8; i++)
      check("R1 R2 R5 mode3 page readback", int'(rbuf[i]), 'hA0 + i);
  endtask

  task automatic t_page_wrap;
    int n;
    for (int i = 0; i < 10; i++) wbuf[i] = 8'h30 + 8'(i);
    eeprom_write(9'h0F6, 10, 1'b1, 0);
    wait_busy(n);
    eeprom_read(9'h0F0, 8, 1'b0);
    // lanes 0..5 take bytes 2..7, lanes 6,7 take bytes 8,9
    for (int i = 0; i < 6; i++) check("R6 page wrap lane", int'(rbuf[i]), 'h32 + i);
    check("R6 page overwrite lane6", int'(rbuf[6]), 'h38);
    check("R6 page overwrite lane7", int'(rbuf[7]), 'h39);
  endtask

  task automatic t_read_wrap;
    int n;
    for (int i = 0; i < 8; i++) wbuf[i] = 8'hC0 + 8'(i);
    eeprom_write(9'h1F8, 8, 1'b1, 0);
    wait_busy(n);
    for (int i = 0; i < 8; i++) wbuf[i] = 8'h10 + 8'(i);
    eeprom_write(9'h000, 8, 1'b1, 0);
    wait_busy(n);
    eeprom_read(9'h1FE, 4, 1'b0);
    check("R4 wrap 1FE", int'(rbuf[0]), 'hC6);
    check("R4 wrap 1FF", int'(rbuf[1]), 'hC7);
    check("R4 wrap 000", int'(rbuf[2]), 'h10);
    check("R4 wrap 001", int'(rbuf[3]), 'h11);
  endtask

  task automatic t_partial_abort;
    int n;
    wbuf[0] = 8'h77;
    eeprom_write(9'h123, 1, 1'b1, 4);
    wait_busy(n);
    check("R8 no busy on partial byte", n, 0);
    eeprom_read(9'h123, 1, 1'b0);
    check("R8 partial store left byte", int'(rbuf[0]), 'h5A);
  endtask

  task automatic t_protected;
    int n;
    wbuf[0] = 8'h99;
    eeprom_write(9'h123, 1, 1'b0, 0);
    wait_busy(n);
    check("R9 no busy when not allowed", n, 0);
    wr_allow = 1'b1;
    eeprom_read(9'h123, 1, 1'b0);
    check("R9 protected byte unchanged", int'(rbuf[0]), 'h5A);
  endtask

  task automatic t_busy_lockout;
    int n;
    wbuf[0] = 8'h44;
    eeprom_write(9'h050, 1, 1'b1, 0);
    wait_clk(8);
    check("R7 busy raised", int'(busy), 1);
    eeprom_read(9'h123, 2, 1'b0);
    check("R10 fetch while busy not driven", int'(oe_seen), 0);
    wbuf[0] = 8'hEE;
    eeprom_write(9'h123, 1, 1'b1, 0);
    wait_busy(n);
    eeprom_read(9'h123, 1, 1'b0);
    check("R10 store while busy ignored", int'(rbuf[0]), 'h5A);
    eeprom_read(9'h050, 1, 1'b0);
    check("R7 first store committed", int'(rbuf[0]), 'h44);
  endtask

  task automatic t_hold;
    logic [7:0] rx, b0, b1;
    logic r;
    spi_begin(1'b0);
    spi_byte(8'h03, rx);
    spi_byte(8'h40, rx);
    b0 = '0;
    for (int i = 7; i >= 4; i--) begin
      spi_bit(1'b0, r);
      b0[i] = r;
    end
    hold_n = 1'b0;
    wait_clk(HALF);
    for (int k = 0; k < 2; k++) begin
      sck = 1'b0; wait_clk(HALF);
      sck = 1'b1; wait_clk(HALF);
    end
    check("R12 so_oe low during hold", int'(so_oe), 0);
    hold_n = 1'b1;
    wait_clk(HALF);
    for (int i = 3; i >= 0; i--) begin
      spi_bit(1'b0, r);
      b0[i] = r;
    end
    spi_byte(8'h00, b1);
    spi_end(1'b0);
    wait_clk(HALF);
    check("R11 byte across hold", int'(b0), 'hA0);
    check("R11 next byte after hold", int'(b1), 'hA1);
  endtask

  task automatic t_bad_opcode;
    logic [7:0] rx;
    spi_begin(1'b0);
    spi_byte(8'h05, rx);
    spi_byte(8'h40, rx);
    spi_byte(8'h00, rx);
    spi_end(1'b0);
    wait_clk(HALF);
    check("R13 unknown command not driven", int'(oe_seen), 0);
    check("R13 unknown command no busy", int'(busy), 0);
    check("R12 so_oe deselected", int'(so_oe), 0);
  endtask

  initial begin
    checks = 0;
    fails = 0;
    done = 0;
    t_reset();
    t_single_write();
    t_page_mode3();
    t_page_wrap();
    t_read_wrap();
    t_partial_abort();
    t_protected();
    t_busy_lockout();
    t_hold();
    t_bad_opcode();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule